// File: doc/BRIEF.md
# SMBus Notify Interrupt and Wake Gating

This block sits beside an SMBus host controller's protocol engine and holds the register state that decides whether two event sources reach the processor. The first source is a level status from the alert input. The second is a received Host Notify message, which arrives as a one-cycle strobe together with the 7-bit address of the device that sent it. The block keeps a small control register, a sticky notify status bit and a read-only capture of the sender's address. It also drives three registered outputs: a PCI-style interrupt request, an SMI request and a wake event.

Each source has its own gate. The alert path is masked by a disable bit, and that bit acts only on the interrupt and SMI path. The notify path is enabled separately for interrupts and for wake. The interrupt-class request is the OR of both gated sources. A routing input sends that request either to the SMI output or to the interrupt line. Every piece of state is cleared only by the resume-domain reset.

Software reaches the registers through a plain register bus. A write is a one-cycle strobe with an address and data. A read is combinational from the address.

Top module: `smb_notify_gate`

## Requirements
- R1: After reset, the control register, the notify status and the captured address are all zero, and `irq_o`, `smi_o` and `wake_o` are low.
- R2: The control register is at offset 0x11. Bit 2 is the alert disable, bit 1 is the notify wake enable and bit 0 is the notify interrupt enable. Bits 7:3 read as 0, and writes to them are ignored.
- R3: The alert contribution to the interrupt-class request is `alert_sts_i` AND NOT bit 2 of the control register.
- R4: The alert disable bit has no effect on `wake_o`.
- R5: `wake_o` is (notify status AND wake enable) OR `other_wake_i`, one clock after those values are present.
- R6: The notify contribution to the interrupt-class request is the notify status AND the interrupt enable. The enable does not decide whether the status sets.
- R7: When the interrupt enable is written to 1 while the notify status is already 1, the request asserts on the next clock.
- R8: When `route_smi_i` is 1, the request drives `smi_o`. When it is 0, the request drives `irq_o`. The two outputs are never high together.
- R9: The address register is at offset 0x14 and is read-only. Bits 7:1 hold the address loaded by the notify strobe, and bit 0 reads as 0. Writes to this offset change nothing.
- R10: The notify status reads at offset 0x10, bit 0, with the other bits read as 0. It sets on the notify strobe and clears when a 1 is written to bit 0. A strobe in the same cycle as the clear wins, and writing 0 has no effect.
- R11: `irq_o` and `smi_o` are registered. Each reflects a status or enable change exactly one clock after the change.
- R12: Reads at any offset other than 0x10, 0x11 and 0x14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low resume-domain reset, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| alert_sts_i | input | 1 | Alert status level |
| notify_evt_i | input | 1 | One-cycle strobe marking a received Host Notify |
| notify_dev_i | input | 7 | Sender address, valid with the strobe |
| route_smi_i | input | 1 | 1 steers the request to SMI, 0 steers it to the interrupt line |
| other_wake_i | input | 1 | Other SMBus wake events, ORed into the wake output |
| irq_o | output | 1 | PCI-style interrupt request |
| smi_o | output | 1 | SMI request |
| wake_o | output | 1 | Wake event |

## Verification
Some properties are checked on every cycle by the assertions:
- `irq_o` and `smi_o` are never high together.
- A notify strobe always sets the status and captures the address on the next edge, even against a clear.
- An enabled notify always raises the routed output one clock later.
- A disabled alert with no enabled notify keeps both request outputs low.
- An enabled notify or `other_wake_i` always raises the wake output.

Other behaviour needs the bench's scenarios:
- register read-back through the bus, including reserved bits;
- ignored writes to the address register;
- the zero value at unmapped offsets;
- the exact cycle on which an output first rises, with the earlier cycle seen to be still low;
- write-0 on the status being ignored;
- the fact that alert masking leaves wake untouched.

// File: rtl/smb_ng_pkg.sv
package smb_ng_pkg;
  localparam int DATA_W = 8;
  localparam int DEV_W  = 7;
  localparam int CTRL_W = 3;
  localparam int BIT_NOTE_IE  = 0;
  localparam int BIT_WAKE_EN  = 1;
  localparam int BIT_ALERT_DIS = 2;

  // a source reaches the request only when allowed
  function automatic logic gate_src(input logic sts, input logic allow);
    return sts & allow;
  endfunction

  // device address sits above a zero bit 0
  function automatic logic [DATA_W-1:0] pack_dev(input logic [DEV_W-1:0] dev);
    return {dev, 1'b0};
  endfunction

  // control register with reserved bits as zero
  function automatic logic [DATA_W-1:0] pack_ctrl(input logic [CTRL_W-1:0] c);
    return {{(DATA_W-CTRL_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/smb_ng_regs.sv
module smb_ng_regs
  import smb_ng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h11,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              notify_evt,
  input  logic [DEV_W-1:0]  notify_dev,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              notify_sts,
  output logic [DEV_W-1:0]  dev_q,
  output logic              notify_set,
  output logic              notify_clr
);
  logic ctrl_we;

  assign ctrl_we    = wr_en && (wr_addr == CTRL_OFS);
  assign notify_set = notify_evt;
  assign notify_clr = wr_en && (wr_addr == STAT_OFS) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  // the set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_sts <= 1'b0;
    end else if (notify_set) begin
      notify_sts <= 1'b1;
    end else if (notify_clr) begin
      notify_sts <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
    end else if (notify_set) begin
      dev_q <= notify_dev;
    end
  end
endmodule

// File: rtl/smb_ng_rdmux.sv
module smb_ng_rdmux
  import smb_ng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h11,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEV_OFS  = 8'h14
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              notify_sts,
  input  logic [DEV_W-1:0]  dev_q,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_OFS) begin
      rd_data = pack_ctrl(ctrl_q);
    end else if (rd_addr == STAT_OFS) begin
      rd_data = {{(DATA_W-1){1'b0}}, notify_sts};
    end else if (rd_addr == DEV_OFS) begin
      rd_data = pack_dev(dev_q);
    end
  end
endmodule

// File: rtl/smb_ng_route.sv
module smb_ng_route
  import smb_ng_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic alert_sts,
  input  logic alert_dis,
  input  logic notify_sts,
  input  logic notify_ie,
  input  logic wake_en,
  input  logic other_wake,
  input  logic route_smi,
  output logic gated_req,
  output logic irq_o,
  output logic smi_o,
  output logic wake_o
);
  logic alert_req;
  logic note_req;
  logic wake_nxt;

  assign alert_req = gate_src(alert_sts, ~alert_dis);
  assign note_req  = gate_src(notify_sts, notify_ie);
  assign gated_req = alert_req | note_req;
  // the alert disable is deliberately absent from the wake path
  assign wake_nxt  = gate_src(notify_sts, wake_en) | other_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      smi_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= gated_req & ~route_smi;
      smi_o  <= gated_req & route_smi;
      wake_o <= wake_nxt;
    end
  end
endmodule

// File: rtl/smb_notify_gate.sv
module smb_notify_gate
  import smb_ng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h11,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEV_OFS  = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              alert_sts_i,
  input  logic              notify_evt_i,
  input  logic [6:0]        notify_dev_i,
  input  logic              route_smi_i,
  input  logic              other_wake_i,
  output logic              irq_o,
  output logic              smi_o,
  output logic              wake_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DEV_W-1:0]  dev_q;
  logic notify_sts;
  logic notify_set;
  logic notify_clr;
  logic gated_req;
  logic alert_dis;
  logic wake_en;
  logic notify_ie;

  assign alert_dis = ctrl_q[BIT_ALERT_DIS];
  assign wake_en   = ctrl_q[BIT_WAKE_EN];
  assign notify_ie = ctrl_q[BIT_NOTE_IE];

  smb_ng_regs #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .notify_evt(notify_evt_i), .notify_dev(notify_dev_i),
    .ctrl_q(ctrl_q), .notify_sts(notify_sts), .dev_q(dev_q),
    .notify_set(notify_set), .notify_clr(notify_clr)
  );

  smb_ng_rdmux #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS), .DEV_OFS(DEV_OFS)
  ) u_rdmux (
    .rd_addr(bus_addr), .ctrl_q(ctrl_q), .notify_sts(notify_sts),
    .dev_q(dev_q), .rd_data(bus_rdata)
  );

  smb_ng_route u_route (
    .clk(clk), .rst_n(rst_n), .alert_sts(alert_sts_i), .alert_dis(alert_dis),
    .notify_sts(notify_sts), .notify_ie(notify_ie), .wake_en(wake_en),
    .other_wake(other_wake_i), .route_smi(route_smi_i), .gated_req(gated_req),
    .irq_o(irq_o), .smi_o(smi_o), .wake_o(wake_o)
  );
endmodule

// File: rtl/smb_notify_gate_chk.sv
module smb_notify_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       notify_evt_i,
  input logic [6:0] notify_dev_i,
  input logic       route_smi_i,
  input logic       other_wake_i,
  input logic       irq_o,
  input logic       smi_o,
  input logic       wake_o,
  input logic       notify_sts,
  input logic       notify_ie,
  input logic       wake_en,
  input logic       alert_dis,
  input logic [6:0] dev_q
);
  // R8
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && smi_o));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_evt_i |=> notify_sts);

  // R9
  dev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_evt_i |=> (dev_q == $past(notify_dev_i)));

  // R6
  note_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_sts && notify_ie && !route_smi_i) |=> irq_o);

  // R7
  pend_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(notify_ie) && notify_sts && route_smi_i) |=> smi_o);

  // R3
  alert_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_dis && !(notify_sts && notify_ie)) |=> (!irq_o && !smi_o));

  // R5
  note_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((notify_sts && wake_en) || other_wake_i) |=> wake_o);
endmodule

bind smb_notify_gate smb_notify_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .notify_evt_i(notify_evt_i),
  .notify_dev_i(notify_dev_i), .route_smi_i(route_smi_i),
  .other_wake_i(other_wake_i), .irq_o(irq_o), .smi_o(smi_o), .wake_o(wake_o),
  .notify_sts(notify_sts), .notify_ie(notify_ie), .wake_en(wake_en),
  .alert_dis(alert_dis), .dev_q(dev_q)
);

// File: tb/smb_notify_gate_tb.sv
`timescale 1ns/1ps
module smb_notify_gate_tb;
  localparam logic [7:0] A_CTRL = 8'h11;
  localparam logic [7:0] A_STAT = 8'h10;
  localparam logic [7:0] A_DEV  = 8'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic alert_sts_i = 1'b0;
  logic notify_evt_i = 1'b0;
  logic [6:0] notify_dev_i = 7'h00;
  logic route_smi_i = 1'b0;
  logic other_wake_i = 1'b0;
  logic irq_o, smi_o, wake_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smb_notify_gate u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alert_sts_i(alert_sts_i),
    .notify_evt_i(notify_evt_i), .notify_dev_i(notify_dev_i),
    .route_smi_i(route_smi_i), .other_wake_i(other_wake_i),
    .irq_o(irq_o), .smi_o(smi_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic notify(input logic [6:0] dev);
    @(negedge clk);
    notify_evt_i = 1'b1; notify_dev_i = dev;
    @(negedge clk);
    notify_evt_i = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {5'b0, wake_o, smi_o, irq_o};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    bus_read(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
    bus_read(A_STAT, d); chk("R1 status", d, 8'h00);
    bus_read(A_DEV, d);  chk("R1 addr", d, 8'h00);
    chk("R1 outputs", outs(), 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    bus_write(A_CTRL, 8'hFD);
    bus_read(A_CTRL, d); chk("R2 reserved bits drop", d, 8'h05);
    bus_write(A_CTRL, 8'h00);
    bus_read(A_CTRL, d); chk("R2 clear", d, 8'h00);
    bus_read(8'h12, d);  chk("R12 unmapped 0x12", d, 8'h00);
    bus_read(8'h00, d);  chk("R12 unmapped 0x00", d, 8'h00);
  endtask

  task automatic t_alert();
    @(negedge clk); alert_sts_i = 1'b1;
    @(negedge clk); #1 chk("R3 alert to irq", outs(), 8'h01);
    bus_write(A_CTRL, 8'h04);
    @(negedge clk); #1 chk("R3 alert masked", outs(), 8'h00);
    bus_write(A_CTRL, 8'h06);
    @(negedge clk); #1 chk("R4 no wake from alert", outs(), 8'h00);
    alert_sts_i = 1'b0;
    bus_write(A_CTRL, 8'h00);
  endtask

  task automatic t_notify_irq();
    logic [7:0] d;
    bus_write(A_CTRL, 8'h01);
    notify(7'h5A);
    #1 chk("R11 irq not yet", outs(), 8'h00);
    @(negedge clk); #1 chk("R6 notify irq", outs(), 8'h01);
    bus_read(A_DEV, d);  chk("R9 addr capture", d, 8'hB4);
    bus_write(A_DEV, 8'hFF);
    bus_read(A_DEV, d);  chk("R9 read-only", d, 8'hB4);
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, d); chk("R10 write 0 ignored", d, 8'h01);
    bus_write(A_STAT, 8'h01);
    bus_read(A_STAT, d); chk("R10 w1c", d, 8'h00);
    #1 chk("R11 irq drops", outs(), 8'h00);
  endtask

  task automatic t_pending();
    logic [7:0] d;
    bus_write(A_CTRL, 8'h00);
    notify(7'h11);
    bus_read(A_STAT, d); chk("R6 status sets while disabled", d, 8'h01);
    chk("R6 no irq while disabled", outs(), 8'h00);
    route_smi_i = 1'b1;
    bus_write(A_CTRL, 8'h01);
    #1 chk("R7 one clock later", outs(), 8'h00);
    @(negedge clk); #1 chk("R7 pending to smi", outs(), 8'h02);
    route_smi_i = 1'b0;
    @(negedge clk); #1 chk("R8 rerouted to irq", outs(), 8'h01);
  endtask

  task automatic t_wake();
    logic [7:0] d;
    bus_write(A_CTRL, 8'h06);
    @(negedge clk); #1 chk("R5 wake with mask set", outs(), 8'h04);
    bus_write(A_CTRL, 8'h00);
    @(negedge clk); #1 chk("R5 wake off", outs(), 8'h00);
    other_wake_i = 1'b1;
    @(negedge clk); #1 chk("R5 other wake", outs(), 8'h04);
    other_wake_i = 1'b0;
    // clear racing with a new strobe: set wins
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 8'h01;
    notify_evt_i = 1'b1; notify_dev_i = 7'h7F;
    @(negedge clk);
    bus_wr = 1'b0; notify_evt_i = 1'b0;
    bus_read(A_STAT, d); chk("R10 set beats clear", d, 8'h01);
    bus_read(A_DEV, d);  chk("R9 top address", d, 8'hFE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (R1..all): actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_alert();
    t_notify_irq();
    t_pending();
    t_wake();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule